// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

An eight-line interrupt controller attached to a byte-wide register bus that has two addresses. Address 0 takes command writes and returns status on reads. Address 1 takes data writes and returns the mask on reads.

Software first writes a start word to address 0. That word fixes the trigger mode and tells the controller which optional setup words follow. It then writes the setup words to address 1: the vector base, then the cascade word if one was requested, then the mode word if one was requested. Once setup is complete, the controller compares pending, unmasked request lines under a priority order that can be rotated. It raises `int_o` when a request outranks everything already in service.

A one-cycle acknowledge strobe latches the vector and moves the winning line into service. The line then stays blocked until software issues an end-of-interrupt command, or until the acknowledge completes when automatic end-of-interrupt is selected.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_o`, `vector_o`, `casc_o`, the mask and both status registers are zero, and no interrupt is raised until a setup sequence completes.
- R2: A command write with bit 4 set starts setup. It records bit 3 (1 = level inputs, 0 = edge inputs), bit 1 (1 = no cascade word) and bit 0 (1 = mode word follows). It clears the mask, the request, in-service, auto-EOI, rotation and read-select state. `int_o` stays low until the last setup word is written.
- R3: The first data write after the start word sets the vector base (bits 7:3). If bit 1 of the start word was clear, the next data write is stored on `casc_o`. If bit 0 was set, a final data write follows, and its bit 1 selects automatic end of interrupt.
- R4: Once setup is complete, a data write loads the mask (bit n = 1 masks line n), and a read of address 1 returns it. A masked request never raises `int_o`.
- R5: With no rotation applied, a lower line number has higher priority. `int_o` is high only when an unmasked pending request ranks above every in-service line.
- R6: On `inta_i`, `vector_o` becomes {base, winning line number} and the winning line enters service. If `int_o` was low, the vector's low three bits are 111 and no state changes.
- R7: In edge mode, a line becomes pending on a 0-to-1 input transition and is cleared by its acknowledge, so a held-high input does not re-request. In level mode, the pending state follows the input one cycle later.
- R8: A command write with bits 4:3 = 00, bit 5 = 1 and bit 6 = 0 clears the highest-priority in-service line.
- R9: A command write with bits 4:3 = 00, bit 5 = 1 and bit 6 = 1 clears the in-service bit of the line given in bits 2:0.
- R10: Bit 7 of such a command rotates priority so that the line after the affected one becomes highest. The affected line is the line cleared by the end-of-interrupt, or, when bit 6 is set, the line in bits 2:0 (with bit 5 clear this only sets the priority).
- R11: With automatic end of interrupt selected, an acknowledge leaves the in-service register unchanged.
- R12: A command write with bits 4:3 = 01 and bit 1 set selects what a read of address 0 returns: bit 0 = 1 returns in-service, bit 0 = 0 returns pending requests. Setup selects pending requests.
- R13: Command writes other than a start word are ignored during setup. A command with bits 4:3 = 00 whose bits 5 and 7 are both clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = command/status, 1 = data/mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_i | input | 8 | Request lines |
| int_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | Single-cycle acknowledge strobe |
| vector_o | output | 8 | Vector latched on acknowledge |
| casc_o | output | 8 | Stored cascade word |

## Verification
The assertions assume that `inta_i` lasts exactly one cycle. They also assume that `irq_i` and the bus inputs change only between clock edges. The stimulus changes every input one nanosecond after a rising edge and raises each strobe for a single cycle. It never issues an acknowledge in the same cycle as a command write, so the order of in-service updates is never ambiguous. The assertions also take eight lines as a power of two, so that the rotation pointer wraps naturally.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_IRQ);
  localparam int unsigned BASE_W  = 8 - IDX_W;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] top_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] rank_o
);
  int kk;
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    rank_o = '0;
    kk     = 0;
    for (int i = 0; i < int'(N); i++) begin
      kk = (int'(top_i) + i) % int'(N);
      if (!hit_o && req_i[kk]) begin
        hit_o  = 1'b1;
        idx_o  = IW'(kk);
        rank_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         ltim_i,
  input  logic         clr_all_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else begin
      prev_q <= irq_i;
      if (clr_all_i)   irr_o <= '0;
      else if (ltim_i) irr_o <= irq_i;
      else             irr_o <= (irr_o | (irq_i & ~prev_q)) & ~ack_clr_i;
    end
  end

  // R7
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ltim_i && !clr_all_i) |=> ((($past(irr_o) & ~$past(ack_clr_i)) & ~irr_o) == '0));
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int unsigned N = NUM_IRQ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [7:0]        wdata_i,
  output logic              init_o,
  output logic              ocw2_o,
  output logic              ready_o,
  output logic              ltim_o,
  output logic              aeoi_o,
  output logic [BASE_W-1:0] base_o,
  output logic [N-1:0]      mask_o,
  output logic [7:0]        casc_o,
  output logic              rdsel_o
);
  init_st_e st_q;
  logic sngl_q, ic4_q;
  logic cmd_wr, dat_wr, ocw3;

  assign cmd_wr = wr_en_i && !addr_i;
  assign dat_wr = wr_en_i &&  addr_i;
  assign init_o = cmd_wr && wdata_i[4];
  assign ocw2_o = cmd_wr && ready_o && (wdata_i[4:3] == 2'b00);
  assign ocw3   = cmd_wr && ready_o && (wdata_i[4:3] == 2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RUN;  ready_o <= 1'b0;
      sngl_q <= 1'b0;  ic4_q <= 1'b0;  ltim_o <= 1'b0;  aeoi_o <= 1'b0;
      base_o <= '0;    mask_o <= '0;   casc_o <= '0;    rdsel_o <= 1'b0;
    end else if (init_o) begin
      st_q <= ST_BASE; ready_o <= 1'b0;
      ltim_o <= wdata_i[3]; sngl_q <= wdata_i[1]; ic4_q <= wdata_i[0];
      aeoi_o <= 1'b0;  mask_o <= '0;   rdsel_o <= 1'b0;
    end else if (dat_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base_o <= wdata_i[7:IDX_W];
          if (!sngl_q)    st_q <= ST_CASC;
          else if (ic4_q) st_q <= ST_MODE;
          else begin st_q <= ST_RUN; ready_o <= 1'b1; end
        end
        ST_CASC: begin
          casc_o <= wdata_i;
          if (ic4_q) st_q <= ST_MODE;
          else begin st_q <= ST_RUN; ready_o <= 1'b1; end
        end
        ST_MODE: begin
          aeoi_o  <= wdata_i[1];
          st_q    <= ST_RUN;
          ready_o <= 1'b1;
        end
        default: if (ready_o) mask_o <= wdata_i[N-1:0];
      endcase
    end else if (ocw3 && wdata_i[1]) begin
      rdsel_o <= wdata_i[0];
    end
  end

  // R2
  init_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (!ready_o && mask_o == '0 && !aeoi_o));
  // R3
  ready_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o)) |-> ($past(dat_wr) && st_q == ST_RUN));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import pic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] irq_i,
  output logic       int_o,
  input  logic       inta_i,
  output logic [7:0] vector_o,
  output logic [7:0] casc_o
);
  localparam int unsigned N  = NUM_IRQ;
  localparam int unsigned IW = IDX_W;

  logic              init_p, ocw2, ready, ltim, aeoi, rdsel;
  logic [BASE_W-1:0] base;
  logic [N-1:0]      mask, irr, isr_q, ack_clr, eoi_clr, win_oh;
  logic [IW-1:0]     top_q, w_idx, w_rank, s_idx, s_rank, lvl, lvl_p1, s_p1;
  logic              w_hit, s_hit, ack_go;

  pic_init_seq #(.N(N)) u_seq (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .init_o(init_p), .ocw2_o(ocw2), .ready_o(ready), .ltim_o(ltim),
    .aeoi_o(aeoi), .base_o(base), .mask_o(mask), .casc_o(casc_o),
    .rdsel_o(rdsel)
  );

  pic_req_reg #(.N(N)) u_req (
    .clk_i, .rst_ni, .irq_i(irq_i[N-1:0]), .ltim_i(ltim), .clr_all_i(init_p),
    .ack_clr_i(ack_clr), .irr_o(irr)
  );

  pic_prio #(.N(N), .IW(IW)) u_win (
    .req_i(irr & ~mask), .top_i(top_q), .hit_o(w_hit), .idx_o(w_idx), .rank_o(w_rank)
  );
  pic_prio #(.N(N), .IW(IW)) u_svc (
    .req_i(isr_q), .top_i(top_q), .hit_o(s_hit), .idx_o(s_idx), .rank_o(s_rank)
  );

  assign int_o   = ready && w_hit && (!s_hit || (w_rank < s_rank));
  assign ack_go  = inta_i && int_o;
  assign win_oh  = {{(N-1){1'b0}}, 1'b1} << w_idx;
  assign ack_clr = (ack_go && !ltim) ? win_oh : '0;
  assign lvl     = wdata_i[IW-1:0];
  assign lvl_p1  = lvl + IW'(1);
  assign s_p1    = s_idx + IW'(1);

  // bit5 = EOI, bit6 = specific level, bit7 = rotate
  always_comb begin
    eoi_clr = '0;
    if (ocw2 && wdata_i[5]) begin
      if (wdata_i[6]) eoi_clr = {{(N-1){1'b0}}, 1'b1} << lvl;
      else if (s_hit) eoi_clr = {{(N-1){1'b0}}, 1'b1} << s_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      top_q    <= '0;
      vector_o <= '0;
    end else begin
      if (init_p) begin
        isr_q <= '0;
        top_q <= '0;
      end else begin
        isr_q <= (isr_q & ~eoi_clr) | ((ack_go && !aeoi) ? win_oh : '0);
        if (ocw2 && wdata_i[7]) begin
          if (wdata_i[6])                 top_q <= lvl_p1;
          else if (wdata_i[5] && s_hit)   top_q <= s_p1;
        end
      end
      if (inta_i) vector_o <= {base, ack_go ? w_idx : {IW{1'b1}}};
    end
  end

  assign rdata_o = addr_i ? mask : (rdsel ? isr_q : irr);

  // R11
  aeoi_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && aeoi && !init_p && !ocw2) |=> (isr_q == $past(isr_q)));
  // R4
  masked_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> ((isr_q & ~$past(isr_q) & $past(mask)) == '0));
  // R2
  init_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_p |=> (isr_q == '0 && irr == '0 && !int_o));
  // R5
  one_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q & ~$past(isr_q)) <= 1);
  // R6
  vec_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> (vector_o[7:IW] == $past(base)));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wd = '0, irq = '0;
  logic [7:0] rdata, vector, casc;
  logic int_w;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .irq_i(irq), .int_o(int_w), .inta_i(inta),
    .vector_o(vector), .casc_o(casc)
  );

  // reference model
  int m_ready = 0, m_st = 0, m_sngl = 0, m_ic4 = 0, m_ltim = 0, m_aeoi = 0;
  int m_base = 0, m_casc = 0, m_mask = 0, m_irr = 0, m_isr = 0;
  int m_top = 0, m_rdsel = 0, m_vec = 0, m_prev = 0;

  function automatic int pick(input int v, input int top, output int rank);
    rank = 0;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = (top + i) % 8;
      if (v[k]) begin rank = i; return k; end
    end
    return -1;
  endfunction

  function automatic int m_int();
    int wi, si, wr, sr;
    wi = pick(m_irr & ~m_mask, m_top, wr);
    si = pick(m_isr, m_top, sr);
    return (m_ready != 0 && wi >= 0 && (si < 0 || wr < sr)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 0; m_st = 0; m_sngl = 0; m_ic4 = 0; m_ltim = 0; m_aeoi = 0;
      m_base = 0; m_casc = 0; m_mask = 0; m_irr = 0; m_isr = 0;
      m_top = 0; m_rdsel = 0; m_vec = 0; m_prev = 0;
    end else begin
      int wi, si, wr, sr, go, n_irr, n_isr, n_top, d;
      bit cmd, dat, start;
      d = int'(wd);
      cmd = wr_en && !addr; dat = wr_en && addr;
      start = cmd && wd[4];
      wi = pick(m_irr & ~m_mask, m_top, wr);
      si = pick(m_isr, m_top, sr);
      go = (inta && m_int() != 0) ? 1 : 0;
      if (start) n_irr = 0;
      else if (m_ltim != 0) n_irr = int'(irq);
      else begin
        n_irr = m_irr | (int'(irq) & ~m_prev);
        if (go != 0) n_irr = n_irr & ~(1 << wi);
      end
      m_prev = int'(irq);
      n_isr = m_isr; n_top = m_top;
      if (cmd && m_ready != 0 && wd[4:3] == 2'b00) begin
        if (wd[5]) begin
          if (wd[6]) n_isr = n_isr & ~(1 << (d % 8));
          else if (si >= 0) n_isr = n_isr & ~(1 << si);
        end
        if (wd[7]) begin
          if (wd[6]) n_top = ((d % 8) + 1) % 8;
          else if (wd[5] && si >= 0) n_top = (si + 1) % 8;
        end
      end
      if (go != 0 && m_aeoi == 0) n_isr = n_isr | (1 << wi);
      if (start) begin n_isr = 0; n_top = 0; end
      if (inta) m_vec = m_base * 8 + ((go != 0) ? wi : 7);
      if (start) begin
        m_st = 1; m_ready = 0; m_ltim = d[3]; m_sngl = d[1]; m_ic4 = d[0];
        m_aeoi = 0; m_mask = 0; m_rdsel = 0;
      end else if (dat) begin
        case (m_st)
          1: begin
            m_base = d / 8;
            if (m_sngl == 0) m_st = 2;
            else if (m_ic4 != 0) m_st = 3;
            else begin m_st = 0; m_ready = 1; end
          end
          2: begin
            m_casc = d;
            if (m_ic4 != 0) m_st = 3; else begin m_st = 0; m_ready = 1; end
          end
          3: begin m_aeoi = d[1]; m_st = 0; m_ready = 1; end
          default: if (m_ready != 0) m_mask = d;
        endcase
      end else if (cmd && m_ready != 0 && wd[4:3] == 2'b01 && wd[1]) begin
        m_rdsel = d[0];
      end
      m_irr = n_irr; m_isr = n_isr; m_top = n_top;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 int_o", int'(int_w), m_int());
      chk("R6 vector_o", int'(vector), m_vec);
      chk("R3 casc_o", int'(casc), m_casc);
      if (addr) chk("R4 mask read", int'(rdata), m_mask);
      else      chk("R12 status read", int'(rdata), (m_rdsel != 0) ? m_isr : m_irr);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1'b1; addr = a; wd = d;
    @(posedge clk); #1; wr_en = 1'b0; addr = 1'b0;
  endtask
  task automatic ack();
    @(posedge clk); #1; inta = 1'b1;
    @(posedge clk); #1; inta = 1'b0;
  endtask
  task automatic setirq(input logic [7:0] v);
    @(posedge clk); #1; irq = v;
    @(posedge clk); #1;
  endtask
  task automatic ichk(input int exp, input string tag);
    @(negedge clk); chk(tag, int'(int_w), exp);
  endtask
  task automatic vchk(input int exp, input string tag);
    @(negedge clk); chk(tag, int'(vector), exp);
  endtask
  task automatic rchk(input logic a, input int exp, input string tag);
    @(posedge clk); #1; addr = a;
    @(negedge clk); chk(tag, int'(rdata), exp);
    @(posedge clk); #1; addr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    ichk(0, "R1 int after reset");
    vchk(0, "R1 vector after reset");
    rchk(1'b0, 0, "R1 status after reset");
    rchk(1'b1, 0, "R1 mask after reset");
    // edge, cascaded, mode word, no auto-EOI
    wr(0, 8'h11);
    wr(0, 8'h20);                       // R13 ignored during setup
    wr(1, 8'h20);
    wr(1, 8'h04);
    wr(1, 8'h01);
    @(negedge clk); chk("R3 cascade word", int'(casc), 8'h04);
    setirq(8'h28);
    ichk(1, "R5 request raises int");
    rchk(1'b0, 8'h28, "R12 pending read");
    ack(); vchk(8'h23, "R6 vector line 3");
    ichk(0, "R5 line 5 below in-service 3");
    setirq(8'h2A);
    ichk(1, "R5 line 1 preempts");
    ack(); vchk(8'h21, "R6 vector line 1");
    wr(0, 8'h0B);
    rchk(1'b0, 8'h0A, "R12 in-service read");
    wr(0, 8'h20);
    rchk(1'b0, 8'h08, "R8 non-specific EOI");
    ichk(0, "R8 line 3 still blocks");
    wr(0, 8'h63);
    rchk(1'b0, 8'h00, "R9 specific EOI");
    ichk(1, "R9 line 5 released");
    ack(); vchk(8'h25, "R6 vector line 5");
    wr(0, 8'h20);
    setirq(8'h00);
    wr(1, 8'h04);
    rchk(1'b1, 8'h04, "R4 mask readback");
    setirq(8'h04);
    ichk(0, "R4 masked line");
    wr(1, 8'h00);
    ichk(1, "R4 unmasked line");
    ack(); vchk(8'h22, "R6 vector line 2");
    wr(0, 8'h20);
    ichk(0, "R7 held edge does not re-request");
    setirq(8'h00);
    // rotation
    wr(0, 8'hC3);
    setirq(8'h11);
    ack(); vchk(8'h24, "R10 line 4 after set-priority");
    wr(0, 8'hA0);
    ack(); vchk(8'h20, "R10 line 0 after rotate");
    setirq(8'h00);
    setirq(8'h10);
    ichk(0, "R10 rotated order blocks line 4");
    wr(0, 8'h20);
    ichk(1, "R10 line 4 after EOI");
    ack(); vchk(8'h24, "R6 vector line 4");
    wr(0, 8'h20);
    setirq(8'h00);
    // level, single, auto-EOI
    wr(0, 8'h1B);
    rchk(1'b1, 0, "R2 mask cleared by start");
    wr(1, 8'h40);
    wr(1, 8'h03);
    setirq(8'h40);
    ichk(1, "R7 level request");
    ack(); vchk(8'h46, "R6 vector line 6");
    wr(0, 8'h0B);
    rchk(1'b0, 8'h00, "R11 auto-EOI leaves in-service clear");
    ichk(1, "R7 level stays pending");
    setirq(8'h00);
    ichk(0, "R7 level follows input");
    ack(); vchk(8'h47, "R6 acknowledge without request");
    // edge, single, no mode word
    wr(0, 8'h12);
    setirq(8'h01);
    ichk(0, "R2 no int during setup");
    wr(1, 8'h80);
    ichk(1, "R3 setup done after base");
    ack(); vchk(8'h80, "R6 vector new base");
    wr(0, 8'h0B);
    rchk(1'b0, 8'h01, "R2 auto-EOI cleared by start");
    wr(0, 8'h00);
    rchk(1'b0, 8'h01, "R13 inert command");
    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule